// File: doc/BRIEF.md
# Level-Interrupt GPIO Controller

A twelve-line general-purpose I/O block that sits behind a small synchronous register port. Each line has an output data bit and an output-enable bit, which leave the block as a pair of pad control vectors. A pad is driven only when its enable bit is 1; otherwise it is left floating. Each pad input passes through a two-flop synchronizer. The synchronized value can be read back, and it also feeds one level detector per line.

Each line has a polarity bit that selects whether a high or a low level counts as active. An active synchronized level sets a sticky status bit, and software clears that bit by writing ones. The status keeps setting itself for as long as the level stays active. An interrupt enable mask then reduces status to a single request line. A 32-bit pin-mux word is stored and presented on a side-band output; the block does nothing else with it.

The register port takes a word index, write and read strobes and write data. Read data is registered: it appears on the cycle after the read strobe and holds until the next read.

Top module: `lgc_gpio`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are zero, `irq` is low and `mux_ctl` is zero.
- R2: Word 0 (output data) and word 1 (output enable) store bits 11:0 of a write. On a read they return those bits with bits 31:12 zero, and they appear on `pad_out` and `pad_oe` on the cycle after the write.
- R3: Word 2 returns the pad inputs after a two-flop synchronizer. A pad change is seen by a read issued two cycles later, and bits 31:12 read zero.
- R4: The polarity bit of line n lives at bit 4*(n mod 8). Lines 0–7 use word 4 and lines 8–11 use word 6. All other bits of those two words read zero.
- R5: With polarity 0 a line is active when its synchronized input is 1; with polarity 1 it is active when the input is 0. An active level sets the line's status bit (word 3) at the next clock edge, whether or not the line is enabled.
- R6: Writing word 3 clears each status bit whose write-data bit is 1, provided the line is not active. Bits written as 0 are unchanged.
- R7: If the same status bit is both set by an active level and cleared in the same cycle, it stays set. So acknowledging while the level persists leaves the request pending.
- R8: Word 5 is the interrupt enable mask, bit n for line n, with 1 meaning enabled. `irq` is high exactly when some bit of status AND enable is 1.
- R9: Word 7 stores all 32 bits of a write, reads them back, and drives them on `mux_ctl` from the cycle after the write.
- R10: Writes to word 2 (input level) have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 12 | Pad input levels |
| pad_out | output | 12 | Pad output data |
| pad_oe | output | 12 | Pad output enable (1 = drive) |
| irq | output | 1 | Combined interrupt request |
| mux_ctl | output | 32 | Stored pin-mux control word |

## Verification
The bench builds the block with its default of twelve lines, a 32-bit data word and a two-stage synchronizer. With twelve lines the polarity fields spill into the second type word, so the split mapping for lines 8–11 is checked alongside the first word. Random pad toggles against random polarity, enable and acknowledge writes make a level-set collide with a clear many times, which exercises the set-wins rule and re-assertion. A cycle model in the bench predicts every read, `irq` and pad output across those runs.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
  // word order is the software-visible map
  typedef enum logic [2:0] {
    W_DOUT  = 3'd0,
    W_DOE   = 3'd1,
    W_DIN   = 3'd2,
    W_STAT  = 3'd3,
    W_POLLO = 3'd4,
    W_IEN   = 3'd5,
    W_POLHI = 3'd6,
    W_MUX   = 3'd7
  } lgc_word_e;

  localparam int unsigned LGC_POL_STRIDE = 4;
  localparam int unsigned LGC_POL_PER_WORD = 8;
endpackage

// File: rtl/lgc_rst_sync.sv
module lgc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_sync_n = rst_q[1];
endmodule

// File: rtl/lgc_sync.sv
module lgc_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/lgc_irq_lane.sv
module lgc_irq_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic pol,
  input  logic clr,
  output logic stat
);
  logic active;
  logic stat_d;
  logic stat_q;

  assign active = lvl ^ pol;

  always_comb begin
    stat_d = stat_q;
    if (clr)    stat_d = 1'b0;
    if (active) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;

  assert_active_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> stat);
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && clr && !active) |=> !stat);
  assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !clr) |=> stat);
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat && !active) |=> !stat);
endmodule

// File: rtl/lgc_gpio.sv
module lgc_gpio #(
  parameter int unsigned NLINES      = 12,
  parameter int unsigned DW          = 32,
  parameter int unsigned WORD_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_word,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic              irq,
  output logic [DW-1:0]     mux_ctl
);
  import lgc_pkg::*;

  localparam int unsigned PF = LGC_POL_STRIDE;
  localparam int unsigned LO = LGC_POL_PER_WORD;

  logic              rst_sync_n;
  lgc_word_e         word;
  logic [NLINES-1:0] din_sync;
  logic [NLINES-1:0] stat_w;
  logic [NLINES-1:0] clr_vec;

  logic [NLINES-1:0] dout_q, doe_q, ien_q, pol_q, pol_d;
  logic [DW-1:0]     mux_q, rdata_q, rdata_d;
  logic              dout_we, doe_we, ien_we, pol_we, mux_we;

  lgc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  lgc_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(pad_in), .dout(din_sync)
  );

  assign word    = lgc_word_e'(bus_word);
  assign dout_we = bus_wr && (word == W_DOUT);
  assign doe_we  = bus_wr && (word == W_DOE);
  assign ien_we  = bus_wr && (word == W_IEN);
  assign mux_we  = bus_wr && (word == W_MUX);
  assign pol_we  = bus_wr && ((word == W_POLLO) || (word == W_POLHI));
  assign clr_vec = (bus_wr && (word == W_STAT)) ? bus_wdata[NLINES-1:0] : '0;

  // per-line level detect and sticky status
  for (genvar g = 0; g < NLINES; g++) begin : g_lane
    lgc_irq_lane u_lane (
      .clk(clk), .rst_n(rst_sync_n), .lvl(din_sync[g]), .pol(pol_q[g]),
      .clr(clr_vec[g]), .stat(stat_w[g])
    );
  end

  // polarity next state: field of line n at PF*(n mod LO)
  always_comb begin
    pol_d = pol_q;
    for (int i = 0; i < NLINES; i++) begin
      if (i < LO) begin
        if (word == W_POLLO) pol_d[i] = bus_wdata[PF*(i%LO)];
      end else begin
        if (word == W_POLHI) pol_d[i] = bus_wdata[PF*(i%LO)];
      end
    end
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    unique case (word)
      W_DOUT:  rdata_d[NLINES-1:0] = dout_q;
      W_DOE:   rdata_d[NLINES-1:0] = doe_q;
      W_DIN:   rdata_d[NLINES-1:0] = din_sync;
      W_STAT:  rdata_d[NLINES-1:0] = stat_w;
      W_IEN:   rdata_d[NLINES-1:0] = ien_q;
      W_MUX:   rdata_d = mux_q;
      W_POLLO: begin
        for (int i = 0; i < NLINES; i++)
          if (i < LO) rdata_d[PF*(i%LO)] = pol_q[i];
      end
      W_POLHI: begin
        for (int i = 0; i < NLINES; i++)
          if (i >= LO) rdata_d[PF*(i%LO)] = pol_q[i];
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dout_q  <= '0;
      doe_q   <= '0;
      ien_q   <= '0;
      pol_q   <= '0;
      mux_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (dout_we) dout_q  <= bus_wdata[NLINES-1:0];
      if (doe_we)  doe_q   <= bus_wdata[NLINES-1:0];
      if (ien_we)  ien_q   <= bus_wdata[NLINES-1:0];
      if (pol_we)  pol_q   <= pol_d;
      if (mux_we)  mux_q   <= bus_wdata;
      if (bus_rd)  rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = dout_q;
  assign pad_oe    = doe_q;
  assign mux_ctl   = mux_q;
  assign irq       = |(stat_w & ien_q);

  assert_mux_store_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && word == W_MUX) |=> (mux_ctl == $past(bus_wdata)));
  assert_oe_store_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && word == W_DOE) |=> (pad_oe == $past(bus_wdata[NLINES-1:0])));
  assert_rd_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && word != W_MUX && word != W_POLLO && word != W_POLHI)
      |=> (bus_rdata[DW-1:NLINES] == '0));
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ien_q == '0) |-> !irq);
  assert_din_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && word == W_DIN) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(mux_ctl)));
endmodule

// File: tb/lgc_gpio_bench.sv
module lgc_gpio_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_word = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;
  logic        irq;
  logic [31:0] mux_ctl;

  int n_chk = 0, n_fail = 0;

  // bench model state
  logic [N-1:0] m_dout = '0, m_doe = '0, m_ien = '0, m_pol = '0, m_stat = '0;
  logic [N-1:0] m_s1 = '0, m_s2 = '0;
  logic [31:0]  m_mux = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lgc_gpio u_lgc_gpio (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq), .mux_ctl(mux_ctl)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected read value per requirements R2..R9
  function automatic logic [31:0] model_read(input logic [2:0] w);
    logic [31:0] r = '0;
    case (w)
      3'd0: r[N-1:0] = m_dout;
      3'd1: r[N-1:0] = m_doe;
      3'd2: r[N-1:0] = m_s2;
      3'd3: r[N-1:0] = m_stat;
      3'd4: for (int i = 0; i < 8; i++) r[4*i] = m_pol[i];
      3'd5: r[N-1:0] = m_ien;
      3'd6: for (int i = 8; i < N; i++) r[4*(i-8)] = m_pol[i];
      default: r = m_mux;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] w);
    case (w)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R3";
      3'd3:       return "R6";
      3'd4, 3'd6: return "R4";
      3'd5:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic model_edge(input bit wr, input logic [2:0] w, input logic [31:0] d);
    logic [N-1:0] clr = (wr && w == 3'd3) ? d[N-1:0] : '0;
    m_stat = (m_stat & ~clr) | (m_s2 ^ m_pol);  // R5, R6, R7
    m_s2 = m_s1;
    m_s1 = pad_in;
    if (wr) begin
      case (w)
        3'd0: m_dout = d[N-1:0];
        3'd1: m_doe  = d[N-1:0];
        3'd4: for (int i = 0; i < 8; i++) m_pol[i] = d[4*i];
        3'd5: m_ien  = d[N-1:0];
        3'd6: for (int i = 8; i < N; i++) m_pol[i] = d[4*(i-8)];
        3'd7: m_mux  = d;
        default: ;
      endcase
    end
  endtask

  // one bus cycle, called at a falling edge
  task automatic cyc(input bit wr, input bit rd, input logic [2:0] w,
                     input logic [31:0] d, input string rtag);
    logic [31:0] exp_rd;
    bus_wr = wr; bus_rd = rd; bus_word = w; bus_wdata = d;
    exp_rd = model_read(w);
    @(posedge clk);
    model_edge(wr, w, d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    if (rd) chk(bus_rdata == exp_rd, (rtag == "") ? tag_of(w) : rtag, "read", bus_rdata, exp_rd);
    chk(irq == |(m_stat & m_ien), "R8", "irq", {31'd0, irq}, {31'd0, |(m_stat & m_ien)});
    chk(pad_out == m_dout && pad_oe == m_doe, "R2", "pads", {4'd0, pad_oe, 4'd0, pad_out},
        {4'd0, m_doe, 4'd0, m_dout});
    chk(mux_ctl == m_mux, "R9", "mux_ctl", mux_ctl, m_mux);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 3'd0, 32'd0, "");
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(pad_oe == '0 && pad_out == '0, "R1", "pads after reset", {20'd0, pad_oe}, 32'd0);
    chk(!irq, "R1", "irq after reset", {31'd0, irq}, 32'd0);
    chk(mux_ctl == '0, "R1", "mux after reset", mux_ctl, 32'd0);
    for (int w = 0; w < 8; w++) cyc(1'b0, 1'b1, 3'(w), 32'd0, "R1");

    // R2 data / enable storage, upper bits zero
    cyc(1'b1, 1'b0, 3'd0, 32'hFFFF_FFFF, "");
    cyc(1'b1, 1'b0, 3'd1, 32'hA5A5_A5A5, "");
    cyc(1'b0, 1'b1, 3'd0, 32'd0, "R2");
    chk(bus_rdata == 32'h0000_0FFF, "R2", "dout literal", bus_rdata, 32'h0000_0FFF);
    cyc(1'b0, 1'b1, 3'd1, 32'd0, "R2");
    chk(bus_rdata == 32'h0000_05A5, "R2", "doe literal", bus_rdata, 32'h0000_05A5);

    // R9 mux word
    cyc(1'b1, 1'b0, 3'd7, 32'hDEAD_BEEF, "");
    cyc(1'b0, 1'b1, 3'd7, 32'd0, "R9");
    chk(mux_ctl == 32'hDEAD_BEEF, "R9", "mux literal", mux_ctl, 32'hDEAD_BEEF);

    // R4 polarity field placement (this also sets status on every idle line)
    cyc(1'b1, 1'b0, 3'd4, 32'hFFFF_FFFF, "");
    cyc(1'b1, 1'b0, 3'd6, 32'hFFFF_FFFF, "");
    cyc(1'b0, 1'b1, 3'd4, 32'd0, "R4");
    chk(bus_rdata == 32'h1111_1111, "R4", "pol lo literal", bus_rdata, 32'h1111_1111);
    cyc(1'b0, 1'b1, 3'd6, 32'd0, "R4");
    chk(bus_rdata == 32'h0000_1111, "R4", "pol hi literal", bus_rdata, 32'h0000_1111);
    cyc(1'b0, 1'b1, 3'd3, 32'd0, "R5");
    chk(bus_rdata == 32'h0000_0FFF, "R5", "active-low all set", bus_rdata, 32'h0000_0FFF);

    // back to active-high, clear everything (inputs low so no re-set)
    cyc(1'b1, 1'b0, 3'd4, 32'd0, "");
    cyc(1'b1, 1'b0, 3'd6, 32'd0, "");
    idle(2);
    cyc(1'b1, 1'b0, 3'd3, 32'hFFFF_FFFF, "");
    cyc(1'b0, 1'b1, 3'd3, 32'd0, "R6");
    chk(bus_rdata == 32'd0, "R6", "all cleared", bus_rdata, 32'd0);

    // R7 persistent level re-latches; R6 w1c after level drops; R8 masking
    pad_in = 12'h808;
    idle(4);
    cyc(1'b0, 1'b1, 3'd3, 32'd0, "R5");
    chk(bus_rdata == 32'h808, "R5", "active-high set", bus_rdata, 32'h808);
    chk(!irq, "R8", "masked irq", {31'd0, irq}, 32'd0);
    cyc(1'b1, 1'b0, 3'd5, 32'h800, "R8");
    chk(irq, "R8", "enabled irq", {31'd0, irq}, 32'd1);
    cyc(1'b1, 1'b0, 3'd3, 32'h808, "");
    cyc(1'b0, 1'b1, 3'd3, 32'd0, "R7");
    chk(bus_rdata == 32'h808 && irq, "R7", "re-latched", bus_rdata, 32'h808);
    pad_in = 12'h000;
    idle(3);
    cyc(1'b1, 1'b0, 3'd3, 32'h008, "");
    cyc(1'b0, 1'b1, 3'd3, 32'd0, "R6");
    chk(bus_rdata == 32'h800, "R6", "partial w1c", bus_rdata, 32'h800);
    cyc(1'b1, 1'b0, 3'd3, 32'h000, "");
    cyc(1'b0, 1'b1, 3'd3, 32'd0, "R6");
    chk(bus_rdata == 32'h800, "R6", "zero write keeps", bus_rdata, 32'h800);
    cyc(1'b1, 1'b0, 3'd3, 32'h800, "");
    chk(!irq, "R8", "irq dropped", {31'd0, irq}, 32'd0);

    // R3 synchronizer latency, R10 input word read-only
    pad_in = 12'h5A3;
    cyc(1'b0, 1'b0, 3'd0, 32'd0, "");
    cyc(1'b0, 1'b1, 3'd2, 32'd0, "R3");
    chk(bus_rdata == 32'd0, "R3", "one cycle not yet", bus_rdata, 32'd0);
    cyc(1'b0, 1'b1, 3'd2, 32'd0, "R3");
    chk(bus_rdata == 32'h5A3, "R3", "two cycles seen", bus_rdata, 32'h5A3);
    cyc(1'b1, 1'b0, 3'd2, 32'hFFFF_FFFF, "R10");
    cyc(1'b0, 1'b1, 3'd2, 32'd0, "R10");
    chk(bus_rdata == 32'h5A3, "R10", "din write ignored", bus_rdata, 32'h5A3);
    for (int w = 0; w < 8; w++) cyc(1'b0, 1'b1, 3'(w), 32'd0, "R10");

    // random mix checked against the cycle model
    for (int k = 0; k < 4000; k++) begin
      logic [2:0]  w = 3'($urandom_range(0, 7));
      logic [31:0] d = $urandom;
      int          op = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) pad_in = 12'($urandom);
      if (op == 0)      cyc(1'b1, 1'b0, w, d, "");
      else if (op == 1) cyc(1'b1, 1'b0, 3'd3, d, "");
      else              cyc(1'b0, 1'b1, w, 32'd0, "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule